// File: doc/BRIEF.md
# Card Host Interrupt and DMA Request Router

This block holds the pending-event bits of a memory-card host controller together with a programmable mask. From them it derives three request lines: one interrupt to the CPU, one DMA request for the receive FIFO and one DMA request for the transmit FIFO. Event sources inside the controller set or clear pending bits with one-cycle strobes. Software writes the mask and can read back both the mask and the pending bits.

A DMA-enable control input moves the two FIFO service requests off the CPU interrupt. While it is high, those requests reach only their DMA lines, whatever the mask holds. The block also decodes writes to the clock start/stop control. A stop write records a clock-off event and aborts any running transfer. A start write re-enables the clock and withdraws that event.

Top module: `card_irq_router`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the mask, all pending bits, the clock-enable status, `cpu_irq`, `rx_dreq`, `tx_dreq` and `xfer_abort` are all zero.
- R2: A mask write stores `mask_wdata[12:0]` and ignores `mask_wdata[15:13]`. The stored value is visible on `mask_q` one cycle after the write.
- R3: A strobe on `set_evt[i]` sets pending bit i, and a strobe on `clr_evt[i]` clears it. When both strobe in the same cycle, the set wins. An untouched bit keeps its value. The result is visible on `pend_q` one cycle later.
- R4: `cpu_irq` is high exactly when, on the previous cycle, some pending bit was set whose effective mask bit was clear.
- R5: While `dma_en` is high, pending bits 5 (receive FIFO) and 6 (transmit FIFO) count as masked for `cpu_irq`, whatever `mask_q` holds.
- R6: `rx_dreq` equals pending bit 5, and `tx_dreq` equals pending bit 6, each as it was on the previous cycle. Neither the mask nor `dma_en` affects them.
- R7: A clock-control write with bit 0 set clears `clk_en_stat`, sets pending bit 4 and pulses `xfer_abort` high for one cycle, on the cycle after the write.
- R8: A clock-control write with bit 1 set and bit 0 clear sets `clk_en_stat` and clears pending bit 4. If both bits are set, the stop action of R7 wins for both `clk_en_stat` and bit 4. A stop or start write also wins over event strobes on bit 4.
- R9: All request outputs are registered. A pending or mask change visible on one cycle affects `cpu_irq`, `rx_dreq` and `tx_dreq` only on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_evt | input | 13 | Per-bit strobes that set pending bits |
| clr_evt | input | 13 | Per-bit strobes that clear pending bits |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | Mask write data; only bits 12:0 are kept |
| clkctl_we | input | 1 | Clock start/stop control write strobe |
| clkctl_wdata | input | 2 | Bit 0 stops the clock, bit 1 starts it |
| dma_en | input | 1 | Routes FIFO requests to the DMA lines only |
| mask_q | output | 13 | Current mask |
| pend_q | output | 13 | Current pending bits |
| clk_en_stat | output | 1 | Clock-enable status |
| xfer_abort | output | 1 | One-cycle pulse that aborts an active transfer |
| cpu_irq | output | 1 | CPU interrupt request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
The hardest situations to reach are the collisions on pending bit 4. There, a clock write carrying both the stop and start bits meets set and clear strobes on that bit in the same cycle. The other hard case is `dma_en` changing while FIFO requests are pending and unmasked. Sparse random strobes rarely line these up, so directed steps build each collision on purpose. They are mixed into a long run of seeded random cycles, and a bench reference model predicts every output one cycle ahead.

// File: rtl/card_irq_router.sv
module card_irq_router #(
  parameter int NEV = 13,
  parameter int WW  = 16,
  parameter int RXB = 5,
  parameter int TXB = 6,
  parameter int CKB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set_evt,
  input  logic [NEV-1:0] clr_evt,
  input  logic           mask_we,
  input  logic [WW-1:0]  mask_wdata,
  input  logic           clkctl_we,
  input  logic [1:0]     clkctl_wdata,
  input  logic           dma_en,
  output logic [NEV-1:0] mask_q,
  output logic [NEV-1:0] pend_q,
  output logic           clk_en_stat,
  output logic           xfer_abort,
  output logic           cpu_irq,
  output logic           rx_dreq,
  output logic           tx_dreq
);
  localparam logic [NEV-1:0] FIFO_BITS = (NEV'(1) << RXB) | (NEV'(1) << TXB);

  logic           stop_wr, start_wr;
  logic [NEV-1:0] pend_n, eff_mask;

  assign stop_wr  = clkctl_we & clkctl_wdata[0];
  assign start_wr = clkctl_we & clkctl_wdata[1];
  assign eff_mask = mask_q | (dma_en ? FIFO_BITS : '0);

  always_comb begin
    pend_n = (pend_q & ~clr_evt) | set_evt;
    if (start_wr) pend_n[CKB] = 1'b0;
    if (stop_wr)  pend_n[CKB] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q      <= '0;
      pend_q      <= '0;
      clk_en_stat <= 1'b0;
      xfer_abort  <= 1'b0;
      cpu_irq     <= 1'b0;
      rx_dreq     <= 1'b0;
      tx_dreq     <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata[NEV-1:0];
      pend_q <= pend_n;
      if (stop_wr)       clk_en_stat <= 1'b0;
      else if (start_wr) clk_en_stat <= 1'b1;
      xfer_abort <= stop_wr;
      cpu_irq    <= |(pend_q & ~eff_mask);
      rx_dreq    <= pend_q[RXB];
      tx_dreq    <= pend_q[TXB];
    end
  end

  assert_rx_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[RXB] |=> ##1 rx_dreq);

  assert_tx_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[TXB] |=> ##1 tx_dreq);

  assert_stop_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clkctl_we && clkctl_wdata[0]) |=> (!clk_en_stat && pend_q[CKB] && xfer_abort));

  assert_start_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clkctl_we && clkctl_wdata == 2'b10) |=> (clk_en_stat && !pend_q[CKB]));

  assert_dma_hides_fifo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && (pend_q & ~FIFO_BITS) == '0) |=> !cpu_irq);

  assert_abort_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> $past(clkctl_we));
endmodule

// File: tb/card_irq_router_tb_top.sv
module card_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] set_evt = '0, clr_evt = '0;
  logic        mask_we = 1'b0;
  logic [15:0] mask_wdata = '0;
  logic        clkctl_we = 1'b0;
  logic [1:0]  clkctl_wdata = '0;
  logic        dma_en = 1'b0;
  logic [12:0] mask_q, pend_q;
  logic        clk_en_stat, xfer_abort, cpu_irq, rx_dreq, tx_dreq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [12:0] m_mask = '0, m_pend = '0;
  logic        m_clk = 1'b0, e_irq = 1'b0, e_rx = 1'b0, e_tx = 1'b0, e_abort = 1'b0;
  bit          fifo_hidden = 1'b0;

  always #4 clk = ~clk;

  card_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_evt(clr_evt),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .clkctl_we(clkctl_we),
    .clkctl_wdata(clkctl_wdata), .dma_en(dma_en), .mask_q(mask_q),
    .pend_q(pend_q), .clk_en_stat(clk_en_stat), .xfer_abort(xfer_abort),
    .cpu_irq(cpu_irq), .rx_dreq(rx_dreq), .tx_dreq(tx_dreq));

  function automatic logic [12:0] next_pend(logic [12:0] p);
    logic [12:0] n;
    n = (p & ~clr_evt) | set_evt;
    if (clkctl_we && clkctl_wdata[1]) n[4] = 1'b0;
    if (clkctl_we && clkctl_wdata[0]) n[4] = 1'b1;
    return n;
  endfunction

  function automatic logic want_irq(logic [12:0] p, logic [12:0] m, logic d);
    logic [12:0] hide;
    hide = m;
    if (d) hide = hide | 13'h060;
    return |(p & ~hide);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check(mask_q == m_mask, "R2 mask", mask_q, m_mask);
    check(pend_q == m_pend, "R3 pending", pend_q, m_pend);
    check(clk_en_stat == m_clk, "R8 clock enable", clk_en_stat, m_clk);
    check(xfer_abort == e_abort, "R7 abort", xfer_abort, e_abort);
    check(cpu_irq == e_irq, fifo_hidden ? "R5 cpu irq" : "R4 cpu irq", cpu_irq, e_irq);
    check({rx_dreq, tx_dreq} == {e_rx, e_tx}, "R6 dma requests", {rx_dreq, tx_dreq}, {e_rx, e_tx});
  endtask

  // inputs are set by the caller just after a falling edge
  task automatic step();
    e_irq       = want_irq(m_pend, m_mask, dma_en);
    fifo_hidden = dma_en && (m_pend[6:5] & ~m_mask[6:5]) != 0;
    e_rx        = m_pend[5];
    e_tx        = m_pend[6];
    e_abort     = clkctl_we && clkctl_wdata[0];
    if (clkctl_we && clkctl_wdata[0]) m_clk = 1'b0;
    else if (clkctl_we && clkctl_wdata[1]) m_clk = 1'b1;
    if (mask_we) m_mask = mask_wdata[12:0];
    m_pend = next_pend(m_pend);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    set_evt = '0; clr_evt = '0; mask_we = 1'b0; clkctl_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: everything low under reset
    check({mask_q, pend_q} == '0, "R1 reset regs", {mask_q, pend_q}, 0);
    check({clk_en_stat, xfer_abort, cpu_irq, rx_dreq, tx_dreq} == '0, "R1 reset outs",
          {clk_en_stat, xfer_abort, cpu_irq, rx_dreq, tx_dreq}, 0);
    rst_n = 1'b1;
    idle();
    step();

    // R2: upper write bits dropped
    mask_we = 1'b1; mask_wdata = 16'hFFFF; step(); idle();
    check(mask_q == 13'h1FFF, "R2 width", mask_q, 13'h1FFF);
    mask_we = 1'b1; mask_wdata = 16'hE000; step(); idle();

    // R9: pending set, irq only one cycle later
    set_evt = 13'h001; step(); idle();
    check(cpu_irq == 1'b0, "R9 latency", cpu_irq, 0);
    step();
    check(cpu_irq == 1'b1, "R9 latency", cpu_irq, 1);
    clr_evt = 13'h001; step(); idle(); step();

    // R5/R6: receive request hidden from CPU under DMA enable
    dma_en = 1'b1; set_evt = 13'h020; step(); idle(); step();
    check(cpu_irq == 1'b0 && rx_dreq == 1'b1, "R5 dma hides rx", {cpu_irq, rx_dreq}, 2'b01);
    dma_en = 1'b0; step(); step();
    check(cpu_irq == 1'b1, "R5 dma off", cpu_irq, 1);
    mask_we = 1'b1; mask_wdata = 16'h0060; step(); idle(); step();
    check(rx_dreq == 1'b1 && cpu_irq == 1'b0, "R6 mask ignored", {rx_dreq, cpu_irq}, 2'b10);

    // R3: set wins over clear
    set_evt = 13'h100; clr_evt = 13'h120; step(); idle();
    check(pend_q[8] && !pend_q[5], "R3 set wins", pend_q, 13'h100);

    // R7/R8: start, stop, both, collisions on bit 4
    clkctl_we = 1'b1; clkctl_wdata = 2'b10; set_evt = 13'h010; step(); idle();
    check(clk_en_stat && !pend_q[4], "R8 start", {clk_en_stat, pend_q[4]}, 2'b10);
    clkctl_we = 1'b1; clkctl_wdata = 2'b01; clr_evt = 13'h010; step(); idle();
    check(!clk_en_stat && pend_q[4] && xfer_abort, "R7 stop", {clk_en_stat, pend_q[4], xfer_abort}, 3'b011);
    step();
    check(!xfer_abort, "R7 pulse", xfer_abort, 0);
    clkctl_we = 1'b1; clkctl_wdata = 2'b10; step(); idle();
    clkctl_we = 1'b1; clkctl_wdata = 2'b11; step(); idle();
    check(!clk_en_stat && pend_q[4], "R8 both bits", {clk_en_stat, pend_q[4]}, 2'b01);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      set_evt      = 13'($urandom & $urandom & $urandom);
      clr_evt      = 13'($urandom & $urandom);
      mask_we      = ($urandom % 8) == 0;
      mask_wdata   = 16'($urandom);
      clkctl_we    = ($urandom % 6) == 0;
      clkctl_wdata = 2'($urandom);
      if (($urandom % 16) == 0) dma_en = ~dma_en;
      step();
    end
    idle();
    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule